// File: doc/BRIEF.md
# Per-Unit Power-Down Sequencer Bank

This block controls power and reset for a bank of up to 32 processing units. Each unit has one 32-bit control/status word on a shared register bus. The word for unit n sits at byte offset 4 × n. Software writes a single request bit to take a unit down or bring it back. The unit's own sequencer then walks it through a fixed set of phases and drives that unit's reset and power-enable lines.

Each unit moves through four phases:

- Active.
- Going down: reset is asserted first and power stays on for a programmable number of cycles.
- Down: power is removed and a "fully down" flag reads 1.
- Self-test: after release, power returns and reset is held for a second programmable delay that stands in for the built-in self-test. Only then does the "fully active" flag read 1 and reset drop.

Both delays are parameters. The defaults give 40 ms of self-test at a 50 MHz clock, and a bench can shorten them. A mask parameter selects which unit slots exist. An absent slot has no sequencer, holds its unit in reset with power off, and reads as zero.

The register bus is plain control and status, with no data stream, so it has no valid/ready pair. A write takes effect at the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `pwr_unit_ctrl`

## Requirements
- R1: After reset, every implemented unit is active: reset low, power enable high, and its word reads 0x2000_0000.
- R2: A write to byte address 4 × n (address bits 1:0 ignored) updates only unit n; a read at that address returns unit n's word.
- R3: Writing bit 0 = 1 to an active unit asserts its reset at the next edge. Power stays on for PD_CYCLES cycles, then drops, and bit 27 reads 1.
- R4: Bits 27 and 29 are never 1 together. Both read 0 while a unit is going down or in self-test.
- R5: Writing bit 0 = 0 to a down unit restores power with reset held for BIST_CYCLES cycles. After that, bit 29 reads 1 and reset is released.
- R6: A request change during a transition is acted on only once the current phase ends. No phase is ever skipped: a unit cannot pass directly between down and active.
- R7: Bit 0 reads back the last written request. All other bits except 27 and 29 read 0, and writes to them have no effect.
- R8: A slot outside VALID_MASK reads 0, ignores writes, and keeps its unit in reset with power enable low.
- R9: For every implemented unit, reset is asserted exactly when bit 29 is 0.
- R10: An implemented unit's power enable is low only while bit 27 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed unit word |
| bus_addr | input | IDX_W+2 | Byte address; bits above 1 select the unit |
| bus_wdata | input | 32 | Write data; only bit 0 is stored |
| bus_rdata | output | 32 | Word of the addressed unit |
| unit_rst | output | NUM_UNITS | Per-unit reset, active high |
| unit_pwr_en | output | NUM_UNITS | Per-unit power enable |

## Verification
The two functions that can fall in the same cycle are a register write that flips a unit's request and that unit's phase timer expiring.

Both orderings are provoked on purpose:
- a request is cleared one write after it was set, while the unit is still going down;
- a request is set again while the unit is in self-test, so the new request is pending when the phase ends.

A behavioural model in the bench tracks each unit's phase and remaining count and is compared against every output on every clock. Assertions on the phase flags catch any direct jump between down and active.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE     = 2'd0,
    PS_GOING_DOWN = 2'd1,
    PS_DOWN       = 2'd2,
    PS_SELF_TEST  = 2'd3
  } pwr_state_e;

  // Bit positions inside a unit word
  localparam int REQ_BIT    = 0;
  localparam int DOWN_BIT   = 27;
  localparam int ACTIVE_BIT = 29;
  localparam int WORD_W     = 32;
endpackage

// File: rtl/pwr_addr_dec.sv
module pwr_addr_dec #(
  parameter int          NUM_UNITS  = 16,
  parameter logic [31:0] VALID_MASK = 32'h0000_1FFF,
  localparam int         IDX_W      = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int         ADDR_W     = IDX_W + 2
) (
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic [IDX_W-1:0]     sel_idx,
  output logic                 sel_hit,
  output logic [NUM_UNITS-1:0] wr_sel
);
  logic [1:0] unused_lsb;
  assign unused_lsb = bus_addr[1:0];
  assign sel_idx    = bus_addr[ADDR_W-1:2];

  always_comb begin
    sel_hit = 1'b0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (VALID_MASK[i] && (sel_idx == IDX_W'(i))) sel_hit = 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_sel
    assign wr_sel[g] = bus_wr && sel_hit && (sel_idx == IDX_W'(g));
  end
endmodule

// File: rtl/pwr_unit_fsm.sv
module pwr_unit_fsm
  import pwr_pkg::*;
#(
  parameter int PD_CYCLES   = 1000,
  parameter int BIST_CYCLES = 2000000,
  localparam int MAX_CYC    = (PD_CYCLES > BIST_CYCLES) ? PD_CYCLES : BIST_CYCLES,
  localparam int CNT_W      = $clog2(MAX_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_req,
  output logic req_q,
  output logic unit_rst,
  output logic unit_pwr_en,
  output logic st_down,
  output logic st_active
);
  pwr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  // Request register: the sequencer samples the value held before this edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     req_q <= 1'b0;
    else if (wr_en) req_q <= wr_req;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PS_ACTIVE: begin
        if (req_q) begin
          state_d = PS_GOING_DOWN;
          cnt_d   = CNT_W'(PD_CYCLES - 1);
        end
      end
      PS_GOING_DOWN: begin
        if (cnt_zero) state_d = PS_DOWN;
        else          cnt_d   = cnt_q - 1'b1;
      end
      PS_DOWN: begin
        if (!req_q) begin
          state_d = PS_SELF_TEST;
          cnt_d   = CNT_W'(BIST_CYCLES - 1);
        end
      end
      PS_SELF_TEST: begin
        if (cnt_zero) state_d = PS_ACTIVE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = PS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_ACTIVE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    unit_rst    = (state_q != PS_ACTIVE);
    unit_pwr_en = (state_q != PS_DOWN);
    st_down     = (state_q == PS_DOWN);
    st_active   = (state_q == PS_ACTIVE);
  end
endmodule

// File: rtl/pwr_rd_mux.sv
module pwr_rd_mux
  import pwr_pkg::*;
#(
  parameter int  NUM_UNITS = 16,
  localparam int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic [IDX_W-1:0]     sel_idx,
  input  logic                 sel_hit,
  input  logic [NUM_UNITS-1:0] req_v,
  input  logic [NUM_UNITS-1:0] down_v,
  input  logic [NUM_UNITS-1:0] active_v,
  output logic [WORD_W-1:0]    rdata
);
  always_comb begin
    rdata = '0;
    if (sel_hit) begin
      rdata[REQ_BIT]    = req_v[sel_idx];
      rdata[DOWN_BIT]   = down_v[sel_idx];
      rdata[ACTIVE_BIT] = active_v[sel_idx];
    end
  end
endmodule

// File: rtl/pwr_unit_ctrl.sv
module pwr_unit_ctrl
  import pwr_pkg::*;
#(
  parameter int          NUM_UNITS   = 16,
  parameter logic [31:0] VALID_MASK  = 32'h0000_1FFF,
  parameter int          PD_CYCLES   = 1000,
  parameter int          BIST_CYCLES = 2000000,
  localparam int         IDX_W       = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int         ADDR_W      = IDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_UNITS-1:0] unit_rst,
  output logic [NUM_UNITS-1:0] unit_pwr_en
);
  logic [IDX_W-1:0]     sel_idx;
  logic                 sel_hit;
  logic [NUM_UNITS-1:0] wr_sel;
  logic [NUM_UNITS-1:0] req_v, st_down, st_active;
  logic [30:0]          unused_wdata;

  // Only the request bit is stored; the rest of the write word is dropped
  assign unused_wdata = bus_wdata[31:1];

  pwr_addr_dec #(.NUM_UNITS(NUM_UNITS), .VALID_MASK(VALID_MASK)) u_dec (
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .sel_idx (sel_idx),
    .sel_hit (sel_hit),
    .wr_sel  (wr_sel)
  );

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    if (VALID_MASK[g]) begin : g_present
      pwr_unit_fsm #(.PD_CYCLES(PD_CYCLES), .BIST_CYCLES(BIST_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_sel[g]),
        .wr_req     (bus_wdata[REQ_BIT]),
        .req_q      (req_v[g]),
        .unit_rst   (unit_rst[g]),
        .unit_pwr_en(unit_pwr_en[g]),
        .st_down    (st_down[g]),
        .st_active  (st_active[g])
      );
    end else begin : g_absent
      // Absent slot: no sequencer, unit held in reset with power off
      assign req_v[g]       = 1'b0;
      assign unit_rst[g]    = 1'b1;
      assign unit_pwr_en[g] = 1'b0;
      assign st_down[g]     = 1'b0;
      assign st_active[g]   = 1'b0;
    end
  end

  pwr_rd_mux #(.NUM_UNITS(NUM_UNITS)) u_rd (
    .sel_idx (sel_idx),
    .sel_hit (sel_hit),
    .req_v   (req_v),
    .down_v  (st_down),
    .active_v(st_active),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/pwr_unit_ctrl_chk.sv
module pwr_unit_ctrl_chk #(
  parameter int          NUM_UNITS  = 16,
  parameter logic [31:0] VALID_MASK = 32'h0000_1FFF
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_UNITS-1:0] unit_rst,
  input logic [NUM_UNITS-1:0] unit_pwr_en,
  input logic [NUM_UNITS-1:0] st_down,
  input logic [NUM_UNITS-1:0] st_active
);
  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_chk
    if (VALID_MASK[g]) begin : g_live
      AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_down[g] && st_active[g])); // R4
      AST_RST_TRACKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        st_active[g] == !unit_rst[g]); // R9
      AST_PWR_OFF_ONLY_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_pwr_en[g] |-> st_down[g]); // R10
      AST_NO_DIRECT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_active[g]) |-> $past(!st_down[g])); // R6
      AST_NO_DIRECT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_down[g]) |-> $past(!st_active[g])); // R6
      AST_RST_BEFORE_PWR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_active[g]) |-> (unit_rst[g] && unit_pwr_en[g])); // R3
    end else begin : g_dead
      AST_ABSENT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        unit_rst[g] && !unit_pwr_en[g]); // R8
    end
  end
endmodule

bind pwr_unit_ctrl pwr_unit_ctrl_chk #(.NUM_UNITS(NUM_UNITS), .VALID_MASK(VALID_MASK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .unit_rst   (unit_rst),
  .unit_pwr_en(unit_pwr_en),
  .st_down    (st_down),
  .st_active  (st_active)
);

// File: tb/pwr_unit_ctrl_bench.sv
module pwr_unit_ctrl_bench;
  localparam int          N    = 16;
  localparam logic [31:0] MASK = 32'h0000_1FFF;
  localparam int          PD   = 5;
  localparam int          BI   = 12;
  localparam int          AW   = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  unit_rst, unit_pwr_en;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // Model: 0 active, 1 going down, 2 down, 3 self-test
  int ms[N];
  int mc[N];
  bit mr[N];

  always #10 clk = ~clk;

  pwr_unit_ctrl #(.NUM_UNITS(N), .VALID_MASK(MASK), .PD_CYCLES(PD), .BIST_CYCLES(BI)) u_pwr_unit_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .unit_rst(unit_rst), .unit_pwr_en(unit_pwr_en));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin ms[i] = 0; mc[i] = 0; mr[i] = 0; end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (MASK[i]) begin
          case (ms[i])
            0: if (mr[i]) begin ms[i] = 1; mc[i] = PD - 1; end
            1: if (mc[i] == 0) ms[i] = 2; else mc[i]--;
            2: if (!mr[i]) begin ms[i] = 3; mc[i] = BI - 1; end
            default: if (mc[i] == 0) ms[i] = 0; else mc[i]--;
          endcase
        end
      end
      if (bus_wr && MASK[bus_addr[AW-1:2]]) mr[bus_addr[AW-1:2]] = bus_wdata[0];
    end
  end

  function automatic logic [31:0] mword(input int i);
    logic [31:0] w = '0;
    if (MASK[i]) begin
      w[0]  = mr[i];
      w[27] = (ms[i] == 2);
      w[29] = (ms[i] == 0);
    end
    return w;
  endfunction

  // Lockstep comparison on every clock, sampled at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        logic er, ep;
        er = MASK[i] ? (ms[i] != 0) : 1'b1;
        ep = MASK[i] ? (ms[i] != 2) : 1'b0;
        check(unit_rst[i] == er, "R9 reset line", 32'(unit_rst[i]), 32'(er));
        check(unit_pwr_en[i] == ep, "R10 power enable", 32'(unit_pwr_en[i]), 32'(ep));
      end
      check(bus_rdata == mword(int'(bus_addr[AW-1:2])), "R4 status word", bus_rdata, mword(int'(bus_addr[AW-1:2])));
    end
    if (cyc > 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input int addr, input logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] d);
    @(negedge clk); #1;
    bus_addr = AW'(addr);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    bit seen;
    idle(3); #1 rst_n = 1'b1;

    rd(0, v);
    check(v == 32'h2000_0000, "R1 reset word", v, 32'h2000_0000);
    check(unit_rst == 16'hE000, "R1 reset lines", 32'(unit_rst), 32'h0000_E000);
    check(unit_pwr_en == 16'h1FFF, "R1 power lines", 32'(unit_pwr_en), 32'h0000_1FFF);

    wr(8, 32'hFFFF_FFFF);
    rd(8, v);
    check(v == 32'h1, "R7 reserved bits dropped", v, 32'h1);
    rd(12, v);
    check(v == 32'h2000_0000, "R2 neighbour untouched", v, 32'h2000_0000);

    wr(56, 32'h1);
    rd(56, v);
    check(v == 32'h0, "R8 absent slot reads zero", v, 32'h0);
    check(unit_rst[14] && !unit_pwr_en[14], "R8 absent slot held", {unit_rst[14], unit_pwr_en[14]}, 32'h2);

    idle(10);
    rd(8, v);
    check(v == 32'h0800_0001, "R3 fully down", v, 32'h0800_0001);

    wr(8, 32'h0);
    rd(8, v);
    check(v == 32'h0, "R5 self-test flags", v, 32'h0);
    check(unit_rst[2] && unit_pwr_en[2], "R5 power on, reset held", {unit_rst[2], unit_pwr_en[2]}, 32'h3);
    idle(20);
    rd(8, v);
    check(v == 32'h2000_0000, "R5 back active", v, 32'h2000_0000);
    check(!unit_rst[2], "R5 reset released", 32'(unit_rst[2]), 32'h0);

    // Clear during going-down: the down phase must still be reached
    wr(20, 32'h1);
    wr(20, 32'h0);
    seen = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (!unit_pwr_en[5]) seen = 1;
    end
    check(seen, "R6 down phase not skipped", 32'(seen), 32'h1);
    idle(20);
    rd(20, v);
    check(v == 32'h2000_0000, "R6 unit 5 returns active", v, 32'h2000_0000);

    // Request again during self-test: active phase must be reached first
    wr(0, 32'h1);
    idle(10);
    wr(0, 32'h0);
    idle(3);
    wr(0, 32'h1);
    seen = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (!unit_rst[0]) seen = 1;
    end
    check(seen, "R6 self-test completes first", 32'(seen), 32'h1);
    idle(15);
    rd(0, v);
    check(v == 32'h0800_0001, "R3 unit 0 down again", v, 32'h0800_0001);

    idle(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule